// File: doc/BRIEF.md
# Ethernet Controller Host Register Port

This block is the host-facing register port of an Ethernet controller. A host reaches it over a simple memory-mapped slave bus with a byte address, separate read and write strobes, and 32-bit data. Three offsets are decoded. One holds an 8-bit register pointer. The other two are data ports that reach the control/status register space and the bus-configuration register space at the index held in the pointer.

Inside the control/status space the block implements four registers with their own behaviour: the main control/status register (index 0), the interrupt mask (index 3), the ring-length register (index 6) and the mode register (index 15). The main register combines status bits that the host clears by writing 1, command bits with a fixed priority, run flags derived from the mode register, and an interrupt flag. Neighbouring logic reports events as one-cycle pulses on a status input. In return the block drives receive and transmit run enables, ring sizes, an init request pulse, a pulse that tells the ring walkers to return to position zero, and an interrupt request.

Top module: `enet_csr_port`

## Requirements
- R1: The pointer lives at byte offset 0x14 and holds 8 bits (write data bits 7:0). Offset 0x10 reaches the control/status space and offset 0x1C reaches the bus-configuration space, both at the pointer's index. Read data is registered and appears on the cycle after the read strobe. Any other offset reads 0 and ignores writes.
- R2: After reset, control register index 0 reads 0x0000_0004 (only the stop bit, bit 2). Every other register and the pointer read 0. Both ring sizes are 1, and irq, run enables and pulses are low.
- R3: A write to index 0 with bit 2 set wins over everything else. The register becomes exactly 0x4, `ring_pos_clr` pulses high on the next cycle, and status pulses arriving in the same cycle are discarded.
- R4: On a write to index 0 without bit 2, a 1 in any of bits 14:8 clears that status bit and a 0 leaves it unchanged.
- R5: On a write to index 0 without bit 2, bit 6 (interrupt enable) takes the written value.
- R6: Writing bit 0 (without bit 2) sets the init bit (bit 0), clears the stop bit and pulses `init_req` high for one cycle on the next cycle.
- R7: Writing bit 1 (without bit 2) sets the start bit (bit 1) and clears the stop bit. Bit 5 and `rx_run` equal start AND NOT mode bit 0. Bit 4 and `tx_run` equal start AND NOT mode bit 1.
- R8: Index 15 (mode) stores and reads back the full written word. The run flags follow a new mode value from the cycle after the write.
- R9: At index 6, write bits 11:8 give the log2 of the receive ring size and bits 15:12 the log2 of the transmit ring size. Each size is 2 to that power, capped at 512. A read returns only those two fields, with all other bits 0.
- R10: Bit 7 (interrupt flag) is 1 exactly while some bit in 14:8 of index 0 is set together with the same bit of index 3 (mask). It is cleared once no such bit remains.
- R11: `irq` is high exactly while bit 7 and bit 6 are both set.
- R12: The status input bit k sets bit 8+k of index 0 (0 init done, 1 transmit done, 2 receive done, 3 memory error, 4 missed frame, 5 collision, 6 transmit timeout). The bit is set on the edge where the pulse is sampled, and a set wins over a simultaneous write-1-to-clear.
- R13: Indices with no special meaning read back the last word written. The two spaces are separate, so a bus-configuration write leaves the same index in the control/status space unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| stat_set | input | 7 | Status event pulses, bit k sets status bit 8+k |
| init_req | output | 1 | One-cycle request to fetch the init block |
| ring_pos_clr | output | 1 | One-cycle request to reset ring positions |
| rx_run | output | 1 | Receive run enable |
| tx_run | output | 1 | Transmit run enable |
| rx_ring_entries | output | 10 | Receive ring size in entries |
| tx_ring_entries | output | 10 | Transmit ring size in entries |
| irq | output | 1 | Interrupt request |

## Verification
A wrong status or mask bit shows first on `irq`, on the cycle after the event or write that caused it. A read of index 0 then shows the exact bit one cycle after the read strobe. A wrong start or mode value shows at once on `rx_run` and `tx_run`. A wrong command priority shows as a missing or extra `init_req` or `ring_pos_clr` pulse on the cycle after the write. Random writes, reads and event pulses are mixed with directed cases: a clear that coincides with a set, stop together with pending events, ring fields above the cap, and generic indices that collide across the two spaces.

// File: rtl/enet_csr_pkg.sv
package enet_csr_pkg;

  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFF_CSR_DATA = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_POINTER  = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_BCR_DATA = 5'h1C;

  localparam int IDX_CTRL  = 0;
  localparam int IDX_MASK  = 3;
  localparam int IDX_RLEN  = 6;
  localparam int IDX_MODE  = 15;

  localparam int CAUSE_N   = 7;
  localparam int CAUSE_LO  = 8;
  localparam int RX_L2_LO  = 8;
  localparam int TX_L2_LO  = 12;
  localparam int L2_W      = 4;

  typedef enum logic [1:0] {
    PSEL_NONE,
    PSEL_PTR,
    PSEL_CSR,
    PSEL_BCR
  } port_sel_e;

  typedef struct packed {
    logic [CAUSE_N-1:0] cause;
    logic               ien;
    logic               stop;
    logic               start;
    logic               init;
  } ctrl_state_t;

  localparam ctrl_state_t CTRL_RESET = '{cause: '0, ien: 1'b0, stop: 1'b1,
                                         start: 1'b0, init: 1'b0};

endpackage

// File: rtl/enet_reg_bank.sv
module enet_reg_bank #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic ent_en;
    assign ent_en = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[i] <= '0;
      end else if (ent_en) begin
        mem_q[i] <= wr_data;
      end
    end
  end

  assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/enet_ring_size.sv
module enet_ring_size #(
  parameter int L2_W   = 4,
  parameter int MAX_L2 = 9,
  parameter int CNT_W  = MAX_L2 + 1
) (
  input  logic [L2_W-1:0]  log2_len,
  output logic [CNT_W-1:0] entries
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_comb begin
    if (int'(log2_len) >= MAX_L2) begin
      entries = ONE << MAX_L2;
    end else begin
      entries = ONE << log2_len;
    end
  end

endmodule

// File: rtl/enet_ctrl_reg.sv
module enet_ctrl_reg
  import enet_csr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CAUSE_N-1:0] wr_clr,
  input  logic               wr_ien,
  input  logic               wr_stop,
  input  logic               wr_start,
  input  logic               wr_init,
  input  logic [CAUSE_N-1:0] stat_set,
  input  logic [CAUSE_N-1:0] cause_mask,
  input  logic               rx_dis,
  input  logic               tx_dis,
  output ctrl_state_t        state,
  output logic               intr,
  output logic               rx_on,
  output logic               tx_on,
  output logic               init_pulse,
  output logic               stop_pulse
);

  ctrl_state_t state_q, state_d;
  logic        state_en;
  logic        init_p_d, stop_p_d;
  logic        init_p_q, stop_p_q;

  always_comb begin
    state_d  = state_q;
    init_p_d = 1'b0;
    stop_p_d = 1'b0;
    if (wr_en && wr_stop) begin
      state_d      = '0;
      state_d.stop = 1'b1;
      stop_p_d     = 1'b1;
    end else begin
      if (wr_en) begin
        state_d.cause = state_q.cause & ~wr_clr;
        state_d.ien   = wr_ien;
        if (wr_init) begin
          state_d.init = 1'b1;
          state_d.stop = 1'b0;
          init_p_d     = 1'b1;
        end
        if (wr_start) begin
          state_d.start = 1'b1;
          state_d.stop  = 1'b0;
        end
      end
      state_d.cause = state_d.cause | stat_set;
    end
  end

  assign state_en = wr_en || (|stat_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CTRL_RESET;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_p_q <= 1'b0;
      stop_p_q <= 1'b0;
    end else begin
      init_p_q <= init_p_d;
      stop_p_q <= stop_p_d;
    end
  end

  assign state      = state_q;
  assign intr       = |(state_q.cause & cause_mask);
  assign rx_on      = state_q.start && !rx_dis;
  assign tx_on      = state_q.start && !tx_dis;
  assign init_pulse = init_p_q;
  assign stop_pulse = stop_p_q;

endmodule

// File: rtl/enet_csr_port.sv
module enet_csr_port
  import enet_csr_pkg::*;
#(
  parameter int PTR_W       = 8,
  parameter int DATA_W      = 32,
  parameter int RING_MAX_L2 = 9,
  parameter int RING_CNT_W  = RING_MAX_L2 + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [CAUSE_N-1:0]    stat_set,
  output logic                  init_req,
  output logic                  ring_pos_clr,
  output logic                  rx_run,
  output logic                  tx_run,
  output logic [RING_CNT_W-1:0] rx_ring_entries,
  output logic [RING_CNT_W-1:0] tx_ring_entries,
  output logic                  irq
);

  localparam int CTRL_USED = CAUSE_LO + CAUSE_N;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // address decode
  port_sel_e sel;
  always_comb begin
    unique case (bus_addr)
      OFF_POINTER:  sel = PSEL_PTR;
      OFF_CSR_DATA: sel = PSEL_CSR;
      OFF_BCR_DATA: sel = PSEL_BCR;
      default:      sel = PSEL_NONE;
    endcase
  end

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;
  logic             csr_wr, bcr_wr;
  logic             hit_ctrl, hit_mask, hit_rlen, hit_mode, hit_special;

  assign ptr_en      = bus_wr && (sel == PSEL_PTR);
  assign ptr_d       = bus_wdata[PTR_W-1:0];
  assign csr_wr      = bus_wr && (sel == PSEL_CSR);
  assign bcr_wr      = bus_wr && (sel == PSEL_BCR);
  assign hit_ctrl    = (ptr_q == PTR_W'(IDX_CTRL));
  assign hit_mask    = (ptr_q == PTR_W'(IDX_MASK));
  assign hit_rlen    = (ptr_q == PTR_W'(IDX_RLEN));
  assign hit_mode    = (ptr_q == PTR_W'(IDX_MODE));
  assign hit_special = hit_ctrl || hit_mask || hit_rlen || hit_mode;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  // mask, mode and ring-length registers
  logic [DATA_W-1:0] mask_q, mode_q;
  logic [L2_W-1:0]   rx_l2_q, tx_l2_q;
  logic              mask_en, mode_en, rlen_en;

  assign mask_en = csr_wr && hit_mask;
  assign mode_en = csr_wr && hit_mode;
  assign rlen_en = csr_wr && hit_rlen;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q <= '0;
    end else if (mode_en) begin
      mode_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rx_l2_q <= '0;
      tx_l2_q <= '0;
    end else if (rlen_en) begin
      rx_l2_q <= bus_wdata[RX_L2_LO +: L2_W];
      tx_l2_q <= bus_wdata[TX_L2_LO +: L2_W];
    end
  end

  // main control/status register
  ctrl_state_t ctrl_state;
  logic        ctrl_intr, ctrl_rx_on, ctrl_tx_on;
  logic        ctrl_wr;
  logic [CAUSE_N-1:0] ctrl_cause;
  logic               ctrl_ien;

  assign ctrl_wr = csr_wr && hit_ctrl;

  enet_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (ctrl_wr),
    .wr_clr     (bus_wdata[CAUSE_LO +: CAUSE_N]),
    .wr_ien     (bus_wdata[6]),
    .wr_stop    (bus_wdata[2]),
    .wr_start   (bus_wdata[1]),
    .wr_init    (bus_wdata[0]),
    .stat_set   (stat_set),
    .cause_mask (mask_q[CAUSE_LO +: CAUSE_N]),
    .rx_dis     (mode_q[0]),
    .tx_dis     (mode_q[1]),
    .state      (ctrl_state),
    .intr       (ctrl_intr),
    .rx_on      (ctrl_rx_on),
    .tx_on      (ctrl_tx_on),
    .init_pulse (init_req),
    .stop_pulse (ring_pos_clr)
  );

  assign ctrl_cause = ctrl_state.cause;
  assign ctrl_ien   = ctrl_state.ien;

  // generic register storage, one bank per space
  logic [DATA_W-1:0] csr_gen_rd, bcr_gen_rd;

  enet_reg_bank #(.IDX_W(PTR_W), .DATA_W(DATA_W)) u_csr_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (csr_wr && !hit_special),
    .wr_idx  (ptr_q),
    .wr_data (bus_wdata),
    .rd_idx  (ptr_q),
    .rd_data (csr_gen_rd)
  );

  enet_reg_bank #(.IDX_W(PTR_W), .DATA_W(DATA_W)) u_bcr_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (bcr_wr),
    .wr_idx  (ptr_q),
    .wr_data (bus_wdata),
    .rd_idx  (ptr_q),
    .rd_data (bcr_gen_rd)
  );

  // ring sizes
  logic [L2_W-1:0]       ring_l2 [2];
  logic [RING_CNT_W-1:0] ring_cnt [2];

  assign ring_l2[0] = rx_l2_q;
  assign ring_l2[1] = tx_l2_q;

  for (genvar r = 0; r < 2; r++) begin : g_ring
    enet_ring_size #(
      .L2_W   (L2_W),
      .MAX_L2 (RING_MAX_L2),
      .CNT_W  (RING_CNT_W)
    ) u_size (
      .log2_len (ring_l2[r]),
      .entries  (ring_cnt[r])
    );
  end

  assign rx_ring_entries = ring_cnt[0];
  assign tx_ring_entries = ring_cnt[1];

  // outputs derived from control state
  assign rx_run = ctrl_rx_on;
  assign tx_run = ctrl_tx_on;
  assign irq    = ctrl_intr && ctrl_ien;

  // read path
  logic [DATA_W-1:0] ctrl_rd, csr_rd, rdata_d, rdata_q;
  logic              rdata_en;

  assign ctrl_rd = {{(DATA_W-CTRL_USED){1'b0}}, ctrl_state.cause, ctrl_intr,
                    ctrl_state.ien, ctrl_rx_on, ctrl_tx_on, 1'b0,
                    ctrl_state.stop, ctrl_state.start, ctrl_state.init};

  always_comb begin
    if (hit_ctrl) begin
      csr_rd = ctrl_rd;
    end else if (hit_mask) begin
      csr_rd = mask_q;
    end else if (hit_rlen) begin
      csr_rd = '0;
      csr_rd[RX_L2_LO +: L2_W] = rx_l2_q;
      csr_rd[TX_L2_LO +: L2_W] = tx_l2_q;
    end else if (hit_mode) begin
      csr_rd = mode_q;
    end else begin
      csr_rd = csr_gen_rd;
    end
  end

  always_comb begin
    unique case (sel)
      PSEL_PTR: rdata_d = {{(DATA_W-PTR_W){1'b0}}, ptr_q};
      PSEL_CSR: rdata_d = csr_rd;
      PSEL_BCR: rdata_d = bcr_gen_rd;
      default:  rdata_d = '0;
    endcase
  end

  assign rdata_en = bus_rd;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/enet_csr_port_chk.sv
module enet_csr_port_chk
  import enet_csr_pkg::*;
#(
  parameter int PTR_W      = 8,
  parameter int RING_CNT_W = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  bus_wr,
  input logic                  wd_stop,
  input logic                  wd_init,
  input logic                  wd_clr_init,
  input logic                  st_init,
  input logic                  st_rx,
  input logic [PTR_W-1:0]      ptr_q,
  input logic [CAUSE_N-1:0]    cause,
  input logic                  ien,
  input logic                  intr,
  input logic                  irq,
  input logic                  rx_run,
  input logic                  tx_run,
  input logic                  init_req,
  input logic                  ring_pos_clr,
  input logic [RING_CNT_W-1:0] rx_ring_entries,
  input logic [RING_CNT_W-1:0] tx_ring_entries
);

  logic wr0;
  assign wr0 = bus_wr && (bus_addr == OFF_CSR_DATA) && (ptr_q == '0);

  assert_stop_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && wd_stop) |=> (ring_pos_clr && !rx_run && !tx_run && (cause == '0) && !irq));

  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && !wd_stop && wd_clr_init && !st_init) |=> !cause[0]);

  assert_init_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |-> $past(wr0 && wd_init && !wd_stop));

  assert_run_from_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_run) || $rose(tx_run)) |-> $past(bus_wr));

  assert_ring_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(rx_ring_entries) == 1) && ($countones(tx_ring_entries) == 1) &&
    (rx_ring_entries <= RING_CNT_W'(512)) && (tx_ring_entries <= RING_CNT_W'(512)));

  assert_flag_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == '0) |-> !intr);

  assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien && intr));

  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rx && !(wr0 && wd_stop)) |=> cause[2]);

endmodule

bind enet_csr_port enet_csr_port_chk #(.PTR_W(PTR_W), .RING_CNT_W(RING_CNT_W)) chk_i (
  .clk             (clk),
  .rst_n           (rst_sync_n),
  .bus_addr        (bus_addr),
  .bus_wr          (bus_wr),
  .wd_stop         (bus_wdata[2]),
  .wd_init         (bus_wdata[0]),
  .wd_clr_init     (bus_wdata[8]),
  .st_init         (stat_set[0]),
  .st_rx           (stat_set[2]),
  .ptr_q           (ptr_q),
  .cause           (ctrl_cause),
  .ien             (ctrl_ien),
  .intr            (ctrl_intr),
  .irq             (irq),
  .rx_run          (rx_run),
  .tx_run          (tx_run),
  .init_req        (init_req),
  .ring_pos_clr    (ring_pos_clr),
  .rx_ring_entries (rx_ring_entries),
  .tx_ring_entries (tx_ring_entries)
);

// File: tb/enet_csr_port_tb_top.sv
module enet_csr_port_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic [6:0]  stat_set;
  logic        init_req, ring_pos_clr, rx_run, tx_run, irq;
  logic [9:0]  rx_ring_entries, tx_ring_entries;

  always #5 clk = ~clk;

  enet_csr_port dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_addr        (bus_addr),
    .bus_wr          (bus_wr),
    .bus_rd          (bus_rd),
    .bus_wdata       (bus_wdata),
    .bus_rdata       (bus_rdata),
    .stat_set        (stat_set),
    .init_req        (init_req),
    .ring_pos_clr    (ring_pos_clr),
    .rx_run          (rx_run),
    .tx_run          (tx_run),
    .rx_ring_entries (rx_ring_entries),
    .tx_ring_entries (tx_ring_entries),
    .irq             (irq)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // reference model state
  logic [7:0]  m_ptr;
  logic [6:0]  m_cause;
  logic        m_ien, m_stop, m_start, m_init;
  logic [31:0] m_mask, m_mode;
  logic [3:0]  m_rl2, m_tl2;
  logic [31:0] m_csr [256];
  logic [31:0] m_bcr [256];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic m_intr();
    return |(m_cause & m_mask[14:8]);
  endfunction

  function automatic logic m_rx_on();
    return m_start && !m_mode[0];
  endfunction

  function automatic logic m_tx_on();
    return m_start && !m_mode[1];
  endfunction

  function automatic logic [9:0] m_entries(input logic [3:0] l2);
    return (l2 >= 4'd9) ? 10'd512 : (10'd1 << l2);
  endfunction

  function automatic logic [31:0] m_ctrl_word();
    return {17'b0, m_cause, m_intr(), m_ien, m_rx_on(), m_tx_on(), 1'b0,
            m_stop, m_start, m_init};
  endfunction

  function automatic logic [31:0] m_read(input logic [4:0] addr);
    logic [31:0] v;
    v = '0;
    if (addr == 5'h14) v = {24'b0, m_ptr};
    else if (addr == 5'h1C) v = m_bcr[m_ptr];
    else if (addr == 5'h10) begin
      case (m_ptr)
        8'd0:    v = m_ctrl_word();
        8'd3:    v = m_mask;
        8'd6:    v = {16'b0, m_tl2, m_rl2, 8'b0};
        8'd15:   v = m_mode;
        default: v = m_csr[m_ptr];
      endcase
    end
    return v;
  endfunction

  task automatic m_reset();
    m_ptr = '0; m_cause = '0; m_ien = 0; m_stop = 1; m_start = 0; m_init = 0;
    m_mask = '0; m_mode = '0; m_rl2 = '0; m_tl2 = '0;
    for (int i = 0; i < 256; i++) begin
      m_csr[i] = '0;
      m_bcr[i] = '0;
    end
  endtask

  task automatic m_update(input logic wr, input logic [4:0] addr,
                          input logic [31:0] wd, input logic [6:0] st);
    logic ctrl_w;
    ctrl_w = wr && addr == 5'h10 && m_ptr == 8'd0;
    if (ctrl_w && wd[2]) begin
      m_cause = '0; m_ien = 0; m_stop = 1; m_start = 0; m_init = 0;
    end else begin
      if (ctrl_w) begin
        m_cause = m_cause & ~wd[14:8];
        m_ien   = wd[6];
        if (wd[0]) begin m_init = 1; m_stop = 0; end
        if (wd[1]) begin m_start = 1; m_stop = 0; end
      end
      m_cause = m_cause | st;
    end
    if (wr && addr == 5'h10 && m_ptr != 8'd0) begin
      case (m_ptr)
        8'd3:    m_mask = wd;
        8'd6:    begin m_rl2 = wd[11:8]; m_tl2 = wd[15:12]; end
        8'd15:   m_mode = wd;
        default: m_csr[m_ptr] = wd;
      endcase
    end
    if (wr && addr == 5'h1C) m_bcr[m_ptr] = wd;
    if (wr && addr == 5'h14) m_ptr = wd[7:0];
  endtask

  // one bus cycle; called and returns at a falling edge
  task automatic op(input string tag, input logic wr, input logic rd,
                    input logic [4:0] addr, input logic [31:0] wd,
                    input logic [6:0] st);
    logic [31:0] erd;
    logic        is_ctrl, e_init, e_clr;
    bus_addr = addr; bus_wr = wr; bus_rd = rd; bus_wdata = wd; stat_set = st;
    erd     = m_read(addr);
    is_ctrl = wr && addr == 5'h10 && m_ptr == 8'd0;
    e_init  = is_ctrl && wd[0] && !wd[2];
    e_clr   = is_ctrl && wd[2];
    @(posedge clk);
    m_update(wr, addr, wd, st);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; stat_set = '0;
    if (rd) chk({tag, " R1 read data"}, bus_rdata, erd);
    chk({tag, " R11 irq"}, {31'b0, irq}, {31'b0, m_intr() && m_ien});
    chk({tag, " R7 rx_run"}, {31'b0, rx_run}, {31'b0, m_rx_on()});
    chk({tag, " R8 tx_run"}, {31'b0, tx_run}, {31'b0, m_tx_on()});
    chk({tag, " R9 rx entries"}, {22'b0, rx_ring_entries}, {22'b0, m_entries(m_rl2)});
    chk({tag, " R9 tx entries"}, {22'b0, tx_ring_entries}, {22'b0, m_entries(m_tl2)});
    chk({tag, " R6 init_req"}, {31'b0, init_req}, {31'b0, e_init});
    chk({tag, " R3 ring_pos_clr"}, {31'b0, ring_pos_clr}, {31'b0, e_clr});
  endtask

  task automatic wr_csr(input string tag, input logic [7:0] idx, input logic [31:0] v,
                        input logic [6:0] st);
    op(tag, 1, 0, 5'h14, {24'b0, idx}, '0);
    op(tag, 1, 0, 5'h10, v, st);
  endtask

  task automatic rd_csr(input string tag, input logic [7:0] idx);
    op(tag, 1, 0, 5'h14, {24'b0, idx}, '0);
    op(tag, 0, 1, 5'h10, '0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    rst_n = 0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0; stat_set = '0;
    m_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R2: reset state
    op("R2 ptr", 0, 1, 5'h14, '0, '0);
    chk("R2 ptr reset", bus_rdata, 32'h0);
    op("R2 ctrl", 0, 1, 5'h10, '0, '0);
    chk("R2 ctrl reset", bus_rdata, 32'h0000_0004);
    chk("R2 entries", {22'b0, rx_ring_entries}, 32'd1);
    rd_csr("R2 mode", 8'd15);
    op("R1 unmapped", 1, 0, 5'h00, 32'hDEAD_BEEF, '0);
    op("R1 unmapped", 0, 1, 5'h08, '0, '0);
    chk("R1 unmapped read", bus_rdata, 32'h0);

    // start with interrupts enabled
    wr_csr("R10 mask", 8'd3, 32'h0000_7F00, '0);
    wr_csr("R7 start", 8'd0, 32'h0000_0042, '0);
    op("R5 readback", 0, 1, 5'h10, '0, '0);
    chk("R5 R7 ctrl word", bus_rdata, 32'h0000_0072);

    // R12: event sets, R10/R11 raise irq
    op("R12 rx done", 0, 0, 5'h00, '0, 7'b000_0100);
    chk("R11 irq raised", {31'b0, irq}, 32'd1);
    // R4: write-1-to-clear
    op("R4 clear", 1, 0, 5'h10, 32'h0000_0440, '0);
    chk("R4 irq dropped", {31'b0, irq}, 32'd0);
    // R12: set wins over clear
    op("R12 set vs clear", 1, 0, 5'h10, 32'h0000_0440, 7'b000_0100);
    op("R12 readback", 0, 1, 5'h10, '0, '0);
    chk("R12 bit kept", {31'b0, bus_rdata[10]}, 32'd1);
    // R10: masked cause raises no flag
    wr_csr("R10 mask off", 8'd3, 32'h0000_0000, 7'b100_0000);
    rd_csr("R10 flag clear", 8'd0);
    chk("R10 flag", {31'b0, bus_rdata[7]}, 32'd0);

    // R8: mode disables receive
    wr_csr("R8 mode", 8'd15, 32'h0000_0001, '0);
    chk("R8 rx off", {31'b0, rx_run}, 32'd0);
    chk("R8 tx on", {31'b0, tx_run}, 32'd1);

    // R9: ring lengths with cap
    wr_csr("R9 rlen", 8'd6, 32'hABCD_F3FF, '0);
    chk("R9 rx 8", {22'b0, rx_ring_entries}, 32'd8);
    chk("R9 tx cap", {22'b0, tx_ring_entries}, 32'd512);
    op("R9 read", 0, 1, 5'h10, '0, '0);
    chk("R9 fields", bus_rdata, 32'h0000_F300);

    // R6: init
    wr_csr("R6 init", 8'd0, 32'h0000_0001, '0);

    // R3: stop with a pending event
    op("R3 stop", 1, 0, 5'h10, 32'h0000_7F47, 7'b111_1111);
    op("R3 readback", 0, 1, 5'h10, '0, '0);
    chk("R3 exact stop", bus_rdata, 32'h0000_0004);

    // R13: generic indices, separate spaces
    wr_csr("R13 csr", 8'd40, 32'h1234_5678, '0);
    op("R13 bcr", 1, 0, 5'h1C, 32'h8765_4321, '0);
    op("R13 csr read", 0, 1, 5'h10, '0, '0);
    chk("R13 csr kept", bus_rdata, 32'h1234_5678);
    op("R13 bcr read", 0, 1, 5'h1C, '0, '0);
    chk("R13 bcr value", bus_rdata, 32'h8765_4321);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int kind;
      logic [31:0] wd;
      logic [6:0]  st;
      logic [7:0]  idx;
      kind = int'($urandom % 7);
      wd   = $urandom;
      if ($urandom % 8 != 0) wd[2] = 1'b0;
      st   = ($urandom % 3 == 0) ? 7'($urandom) : 7'b0;
      case ($urandom % 5)
        0: idx = 8'd0;
        1: idx = 8'd3;
        2: idx = 8'd6;
        3: idx = 8'd15;
        default: idx = 8'($urandom);
      endcase
      case (kind)
        0: op("R1 rnd ptr", 1, 0, 5'h14, {24'b0, idx}, st);
        1: op("R4 rnd csr wr", 1, 0, 5'h10, wd, st);
        2: op("R13 rnd bcr wr", 1, 0, 5'h1C, wd, st);
        3: op("R10 rnd csr rd", 0, 1, 5'h10, '0, st);
        4: op("R13 rnd bcr rd", 0, 1, 5'h1C, '0, st);
        5: op("R1 rnd ptr rd", 0, 1, 5'h14, '0, st);
        default: op("R12 rnd idle", 0, 0, 5'h00, '0, st);
      endcase
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule